// File: doc/BRIEF.md
# SPI Register Access Port with Address Auto-Decrement

This block is a serial slave that gives an external host byte access to an on-chip register bank over a four-wire SPI link. Every frame begins with a 16-bit instruction word. Its top bit selects the direction and its lower fifteen bits name the starting register. After the instruction, the host can move any number of 8-bit data bytes while chip select stays low. After each byte the working address moves one step down, and below zero it wraps to the top of the 15-bit space.

The link runs in SPI mode 0 with the most significant bit first. The host-to-device line is sampled on rising serial-clock edges. The device-to-host line changes after falling edges and is released (output enable low) whenever chip select is high. All three inputs pass through a synchronizer into the system clock domain. The register bank sees a simple strobe interface. Each read strobe is answered on `reg_rdata_i` in the following cycle. A read strobe is issued once for every byte the host can clock out, so a downstream tracker can follow the order of accesses, for example a descending sweep from 0x0203 to 0x0200 in one 48-clock frame.

Top module: `spi_reg_access`

## Requirements
- R1: The first 16 bits after chip select falls, MSB first, form the instruction: bit 15 = 1 means read and bit 15 = 0 means write, and bits 14:0 give the start address. A read instruction produces a read strobe carrying that address.
- R2: Read data returns MSB first on `spi_miso_o`. A new bit appears after each falling serial clock, and the first data bit is valid before the 17th rising edge.
- R3: In a write frame, every complete group of 8 data bits produces one single-cycle write strobe carrying that byte. The first byte goes to the instruction address.
- R4: In both directions, each later byte in the same frame uses the address one below the byte before it.
- R5: Stepping down from address 0x0000 gives 0x7FFF.
- R6: A read frame issues exactly one read strobe at the end of the instruction and one at the end of each completed data byte, so n bytes give n+1 strobes. Every strobe lasts a single cycle, and a read strobe and a write strobe never occur in the same cycle.
- R7: `spi_miso_oe_o` is high exactly while chip select is low. `spi_miso_o` is 0 during the instruction phase.
- R8: When chip select rises, any partly received byte or instruction is discarded with no strobe, and the next frame starts a fresh instruction.
- R9: A 48-clock read frame starting at 0x0203 returns the contents of 0x0203, 0x0202, 0x0201 and 0x0200, in that order.
- R10: During and right after reset, with chip select high, no strobe is active and `spi_miso_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_clk_i | input | 1 | Serial clock from the host, idle low |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| spi_miso_oe_o | output | 1 | Output enable for the data-out pad driver |
| reg_addr_o | output | ADDR_W | Register address for the current strobe |
| reg_wdata_o | output | DATA_W | Write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | DATA_W | Read data, valid the cycle after `reg_re_o` |

## Verification
The bench aims at the address wrap in both directions. A design that borrows incorrectly would jump to 0xFFFF or stop at zero, and the data read back or the write address would then be wrong. It cuts frames off in the middle of a byte and in the middle of the instruction. A design that keeps partial state would emit a stray write or shift the next instruction by a few bits. It also counts the read strobes in every read frame and compares the bytes returned in a full 48-clock sweep. That catches a missing lookahead fetch, which returns stale data for the second byte, and an off-by-one in the bit counter, which rotates the returned bytes.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } spi_phase_e;
endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  localparam int NPIN = 3;
  // pin order: 0 sclk, 1 cs_n, 2 mosi; cs_n resets inactive
  localparam logic [NPIN-1:0] RST_VAL = 3'b010;

  logic [NPIN-1:0] pin_in;
  logic [NPIN-1:0] pin_sync;
  logic            sclk_d_q;

  assign pin_in = {mosi_i, cs_ni, sclk_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
    end
    assign pin_sync[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= pin_sync[0];
  end

  assign sclk_rise_o = pin_sync[0] & ~sclk_d_q;
  assign sclk_fall_o = ~pin_sync[0] & sclk_d_q;
  assign cs_act_o    = ~pin_sync[1];
  assign mosi_o      = pin_sync[2];
endmodule

// File: rtl/spi_ra_frame.sv
module spi_ra_frame
  import spi_ra_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              cs_act_i,
  input  logic              mosi_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic              rd_phase_o,
  output logic              byte_start_o
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  spi_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  sh_q;
  logic [CMD_W-1:0]  sh_nxt;
  logic              rd_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] cur_dec;
  logic [ADDR_W-1:0] acc_q;
  logic [DATA_W-1:0] wd_q;
  logic              we_q;
  logic              re_q;

  assign sh_nxt  = {sh_q[CMD_W-2:0], mosi_i};
  assign cur_dec = cur_q - ADDR_W'(1);  // natural wrap 0 -> all ones

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      cur_q   <= '0;
      acc_q   <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        rd_q    <= 1'b0;
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (phase_q == PH_CMD) begin
          if (cnt_q == CMD_LAST) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            rd_q    <= sh_nxt[CMD_W-1];
            cur_q   <= sh_nxt[ADDR_W-1:0];
            if (sh_nxt[CMD_W-1]) begin
              re_q  <= 1'b1;
              acc_q <= sh_nxt[ADDR_W-1:0];
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == DATA_LAST) begin
            cnt_q <= '0;
            cur_q <= cur_dec;
            if (rd_q) begin
              // lookahead fetch for the byte about to start
              re_q  <= 1'b1;
              acc_q <= cur_dec;
            end else begin
              we_q  <= 1'b1;
              acc_q <= cur_q;
              wd_q  <= sh_nxt[DATA_W-1:0];
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign reg_addr_o   = acc_q;
  assign reg_wdata_o  = wd_q;
  assign reg_we_o     = we_q;
  assign reg_re_o     = re_q;
  assign rd_phase_o   = (phase_q == PH_DATA) && rd_q;
  assign byte_start_o = (cnt_q == '0);
endmodule

// File: rtl/spi_ra_shift_out.sv
module spi_ra_shift_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              rd_phase_i,
  input  logic              byte_start_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              miso_o
);
  logic              rvalid_q;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] sh_q;
  logic              miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      buf_q    <= '0;
    end else begin
      rvalid_q <= rd_strobe_i;
      if (rvalid_q) buf_q <= rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act_i) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else if (fall_i && rd_phase_i) begin
      if (byte_start_i) begin
        miso_q <= buf_q[DATA_W-1];
        sh_q   <= {buf_q[DATA_W-2:0], 1'b0};
      end else begin
        miso_q <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_clk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic sclk_rise, sclk_fall, cs_act, mosi_s;
  logic rd_phase, byte_start;
  logic re_int;

  spi_ra_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (spi_clk_i),
    .cs_ni       (spi_cs_ni),
    .mosi_i      (spi_mosi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_act_o    (cs_act),
    .mosi_o      (mosi_s)
  );

  spi_ra_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (sclk_rise),
    .cs_act_i     (cs_act),
    .mosi_i       (mosi_s),
    .reg_addr_o   (reg_addr_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_we_o     (reg_we_o),
    .reg_re_o     (re_int),
    .rd_phase_o   (rd_phase),
    .byte_start_o (byte_start)
  );

  spi_ra_shift_out #(.DATA_W(DATA_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .fall_i       (sclk_fall),
    .rd_phase_i   (rd_phase),
    .byte_start_i (byte_start),
    .rd_strobe_i  (re_int),
    .rdata_i      (reg_rdata_i),
    .miso_o       (spi_miso_o)
  );

  assign reg_re_o      = re_int;
  // pad release follows the raw select so the line frees at once
  assign spi_miso_oe_o = ~spi_cs_ni;
endmodule

// File: rtl/spi_ra_checker.sv
module spi_ra_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_cs_ni,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_we_o,
  input logic              reg_re_o
);
  logic [2:0]        cs_hi_cnt;
  logic              seen_re, seen_we;
  logic [ADDR_W-1:0] last_re, last_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_hi_cnt <= '0;
      seen_re   <= 1'b0;
      seen_we   <= 1'b0;
      last_re   <= '0;
      last_we   <= '0;
    end else begin
      if (!spi_cs_ni)          cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 4) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (spi_cs_ni) begin
        seen_re <= 1'b0;
        seen_we <= 1'b0;
      end else begin
        if (reg_re_o) begin seen_re <= 1'b1; last_re <= reg_addr_o; end
        if (reg_we_o) begin seen_we <= 1'b1; last_we <= reg_addr_o; end
      end
    end
  end

  a_r6_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_re_o && reg_we_o));

  a_r6_re_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  a_r3_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt == 3'd4) |-> (!reg_re_o && !reg_we_o));

  // R5 wrap is covered by the modular decrement below
  a_r4_rd_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_o && seen_re && !spi_cs_ni) |-> (reg_addr_o == last_re - ADDR_W'(1)));

  a_r4_wr_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && seen_we && !spi_cs_ni) |-> (reg_addr_o == last_we - ADDR_W'(1)));
endmodule

bind spi_reg_access spi_ra_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spi_cs_ni  (spi_cs_ni),
  .reg_addr_o (reg_addr_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o)
);

// File: tb/tb_spi_reg_access.sv
module tb_spi_reg_access;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, miso_oe;
  logic [14:0] addr;
  logic [7:0]  wdata;
  logic        we, re;
  logic [7:0]  rdata = 8'h00;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [14:0] re_log [64];
  logic [14:0] we_log [64];
  logic [7:0]  wd_log [64];
  int re_n = 0, we_n = 0;
  int dual_err = 0, pulse_err = 0;
  logic re_prev = 1'b0, we_prev = 1'b0;

  logic [7:0] tx_bytes [8];
  logic [7:0] rx_bytes [8];
  int cmd_ones, oe_bad;

  always #4 clk = ~clk;

  spi_reg_access dut (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_clk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] bank_val(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5C;
  endfunction

  // register bank model and strobe monitor
  always @(posedge clk) begin
    if (re) rdata <= bank_val(addr);
    if (rst_n) begin
      if (re) begin re_log[re_n % 64] <= addr; re_n <= re_n + 1; end
      if (we) begin
        we_log[we_n % 64] <= addr;
        wd_log[we_n % 64] <= wdata;
        we_n <= we_n + 1;
      end
      if (re && we) dual_err <= dual_err + 1;
      if ((re && re_prev) || (we && we_prev)) pulse_err <= pulse_err + 1;
    end
    re_prev <= re;
    we_prev <= we;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic d, output logic s);
    mosi = d;
    wait_clks(HALF);
    if (!miso_oe) oe_bad++;
    s = miso;
    sclk = 1'b1;
    wait_clks(HALF);
    sclk = 1'b0;
  endtask

  task automatic spi_frame(input logic [15:0] cmd, input int nbytes,
                           input int cmd_bits, input int extra_bits);
    logic s;
    cmd_ones = 0;
    oe_bad = 0;
    cs_n = 1'b0;
    wait_clks(HALF);
    for (int i = 15; i > 15 - cmd_bits; i--) begin
      bit_x(cmd[i], s);
      if (s) cmd_ones++;
    end
    for (int b = 0; b < nbytes; b++)
      for (int i = 7; i >= 0; i--) begin
        bit_x(tx_bytes[b][i], s);
        rx_bytes[b][i] = s;
      end
    for (int i = 0; i < extra_bits; i++) bit_x(1'b1, s);
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(4 * HALF);
  endtask

  task automatic t_reset;
    wait_clks(3);
    chk(!re && !we, "R10", "strobes in reset", {re, we}, 0);
    chk(miso == 1'b0, "R10", "miso in reset", miso, 0);
    rst_n = 1'b1;
    wait_clks(4);
    chk(!re && !we, "R10", "strobes after reset", {re, we}, 0);
    chk(miso_oe == 1'b0, "R7", "oe with cs high", miso_oe, 0);
  endtask

  task automatic t_read_single;
    int r0 = re_n;
    spi_frame(16'h8010, 1, 16, 0);
    chk(rx_bytes[0] == bank_val(15'h0010), "R2", "read byte", rx_bytes[0], bank_val(15'h0010));
    chk(re_log[r0 % 64] == 15'h0010, "R1", "first read addr", re_log[r0 % 64], 15'h0010);
    chk(re_n - r0 == 2, "R6", "read strobes for 1 byte", re_n - r0, 2);
    chk(cmd_ones == 0, "R7", "miso ones in cmd phase", cmd_ones, 0);
    chk(oe_bad == 0, "R7", "oe low while selected", oe_bad, 0);
    chk(miso_oe == 1'b0, "R7", "oe after frame", miso_oe, 0);
  endtask

  task automatic t_sweep;
    int r0 = re_n;
    spi_frame(16'h8203, 4, 16, 0);
    for (int k = 0; k < 4; k++) begin
      logic [14:0] a = 15'h0203 - 15'(k);
      chk(rx_bytes[k] == bank_val(a), "R9", "sweep byte", rx_bytes[k], bank_val(a));
      chk(re_log[(r0 + k) % 64] == a, "R4", "sweep read addr", re_log[(r0 + k) % 64], a);
    end
    chk(re_n - r0 == 5, "R6", "read strobes for 4 bytes", re_n - r0, 5);
  endtask

  task automatic t_read_wrap;
    logic [14:0] exp_a [3];
    exp_a[0] = 15'h0001; exp_a[1] = 15'h0000; exp_a[2] = 15'h7FFF;
    spi_frame(16'h8001, 3, 16, 0);
    for (int k = 0; k < 3; k++)
      chk(rx_bytes[k] == bank_val(exp_a[k]), "R5", "read wrap byte", rx_bytes[k], bank_val(exp_a[k]));
  endtask

  task automatic t_write;
    int w0 = we_n;
    tx_bytes[0] = 8'h3C; tx_bytes[1] = 8'hC3; tx_bytes[2] = 8'h5A;
    spi_frame(16'h0123, 3, 16, 0);
    chk(we_n - w0 == 3, "R3", "write strobes", we_n - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(we_log[(w0 + k) % 64] == 15'h0123 - 15'(k), "R4", "write addr",
          we_log[(w0 + k) % 64], 15'h0123 - 15'(k));
      chk(wd_log[(w0 + k) % 64] == tx_bytes[k], "R3", "write data",
          wd_log[(w0 + k) % 64], tx_bytes[k]);
    end
  endtask

  task automatic t_write_wrap;
    int w0 = we_n;
    tx_bytes[0] = 8'h11; tx_bytes[1] = 8'h22;
    spi_frame(16'h0000, 2, 16, 0);
    chk(we_log[w0 % 64] == 15'h0000, "R5", "write wrap addr0", we_log[w0 % 64], 0);
    chk(we_log[(w0 + 1) % 64] == 15'h7FFF, "R5", "write wrap addr1", we_log[(w0 + 1) % 64], 15'h7FFF);
  endtask

  task automatic t_abort_byte;
    int w0 = we_n;
    int r0;
    tx_bytes[0] = 8'hA7;
    spi_frame(16'h0050, 1, 16, 5);
    chk(we_n - w0 == 1, "R8", "writes after mid-byte abort", we_n - w0, 1);
    chk(wd_log[w0 % 64] == 8'hA7, "R8", "kept byte data", wd_log[w0 % 64], 8'hA7);
    r0 = re_n;
    spi_frame(16'h8077, 1, 16, 0);
    chk(re_log[r0 % 64] == 15'h0077, "R8", "fresh cmd after abort", re_log[r0 % 64], 15'h0077);
    chk(rx_bytes[0] == bank_val(15'h0077), "R8", "read after abort", rx_bytes[0], bank_val(15'h0077));
  endtask

  task automatic t_abort_cmd;
    int w0 = we_n;
    int r0 = re_n;
    spi_frame(16'h8123, 0, 9, 0);
    chk(re_n == r0 && we_n == w0, "R8", "strobes after cmd abort", re_n - r0 + we_n - w0, 0);
    tx_bytes[0] = 8'h96;
    spi_frame(16'h0321, 1, 16, 0);
    chk(we_log[w0 % 64] == 15'h0321, "R8", "write addr after cmd abort", we_log[w0 % 64], 15'h0321);
    chk(wd_log[w0 % 64] == 8'h96, "R3", "write data after cmd abort", wd_log[w0 % 64], 8'h96);
  endtask

  task automatic t_strobe_shape;
    chk(dual_err == 0, "R6", "read and write same cycle", dual_err, 0);
    chk(pulse_err == 0, "R6", "strobe longer than one cycle", pulse_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_single();
    t_sweep();
    t_read_wrap();
    t_write();
    t_write_wrap();
    t_abort_byte();
    t_abort_cmd();
    t_strobe_shape();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule